// File: doc/BRIEF.md
# Shadow RAM Region Attribute Controller

This block sits beside the memory decoder of a small-system chipset. It holds a handful of configuration bytes behind an indexed I/O pair. A byte written to the index port picks a register. A write to the data port then updates that register, and a read of the data port returns it. From those bytes, the block classifies every 20-bit memory address in the top 256 KB of the first megabyte. For each address it tells the memory path where a read is served, and whether a write goes to on-board DRAM, goes to the expansion bus, or is discarded.

The upper area is split into four 64 KB segments. The three lower segments are each split again into four 16 KB blocks. Every block has its own enable bit, and each segment has a master enable. One shared bit sets where writes to a shadowed block go. The top segment is handled differently: a single mode bit either serves reads from DRAM and discards writes, or serves reads from the bus while writes land in DRAM so the copy can be filled. The decode is combinational and always uses the current register contents.

Top module: `shadow_region_ctl`

## Requirements
- R1: A write to I/O port 0x22 loads the 8-bit index register on the next clock edge.
- R2: When `ioAddr` is 0x24, `ioRdData` returns the register selected by the index. For any other `ioAddr`, it returns 0xFF.
- R3: A data write (port 0x24) changes storage only when the index is in the range 0x10 to 0x14. Writes with any other index have no effect, and those registers read 0x00.
- R4: After reset, register 0x10 reads 0x3F, register 0x11 reads 0xF0, and registers 0x12, 0x13 and 0x14 read 0x00.
- R5: For addresses 0xF0000 to 0xFFFFF, behaviour depends on register 0x11 bit 7. When the bit is 0, `rdInternal` is 1 and `wrTarget` is 10 (dropped). When the bit is 1, `rdInternal` is 0 and `wrTarget` is 01 (DRAM).
- R6: In 0xC0000 to 0xCFFFF, 16 KB block n (address bits 15:14) is shadowed only if register 0x11 bit 4 is 1 and register 0x13 bit 4+n is 1.
- R7: In 0xD0000 to 0xDFFFF, block n is shadowed only if register 0x11 bit 5 is 1 and register 0x12 bit n is 1.
- R8: In 0xE0000 to 0xEFFFF, block n is shadowed only if register 0x11 bit 6 is 1 and register 0x12 bit 4+n is 1.
- R9: A shadowed C, D or E block drives `rdInternal` to 1. Its `wrTarget` is 01 (DRAM) when register 0x11 bit 3 is 1, and 00 (bus) when that bit is 0. These blocks never produce 10.
- R10: An unshadowed C, D or E block drives `rdInternal` to 0 and `wrTarget` to 00.
- R11: For addresses below 0xC0000, `inRange` is 0, `rdInternal` is 0 and `wrTarget` is 00. From 0xC0000 upward, `inRange` is 1.
- R12: A register write changes the decode only from the clock edge that stores it. Before that edge, the outputs still reflect the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ioWrEn | input | 1 | I/O write strobe, sampled on the clock edge |
| ioAddr | input | 16 | I/O port address |
| ioWrData | input | 8 | I/O write data |
| ioRdData | output | 8 | I/O read data (combinational) |
| memAddr | input | 20 | Memory address to classify |
| inRange | output | 1 | Address lies in 0xC0000 to 0xFFFFF |
| rdInternal | output | 1 | Read is served from on-board DRAM |
| wrTarget | output | 2 | Write route: 00 bus, 01 DRAM, 10 dropped |

## Verification
The hardest state to reach from the ports is one where the master enable, the block bit and the write-policy bit disagree within a single segment. For example, a block bit may be set while its segment master is off, or the D and E halves of register 0x12 may hold different patterns. Reaching such a state takes several index and data writes, each separated by clock edges.

The stimulus loads asymmetric patterns such as 0x5A and 0xC3, turns on one master at a time, and after every configuration sweeps all sixteen 16 KB blocks and several addresses below the window. A reference model in the bench tracks the same register writes and predicts every output on every cycle. It also checks, in the cycle before a write's edge, that the old decode still holds.

// File: rtl/shadow_cfg_pkg.sv
package shadow_cfg_pkg;
  typedef enum logic [1:0] {
    WR_EXT  = 2'b00,
    WR_DRAM = 2'b01,
    WR_DROP = 2'b10
  } wrTarget_e;

  typedef struct packed {
    logic loadIndex;
    logic storeData;
  } cfgStrobe_t;
endpackage

// File: rtl/shadow_cfg_ctrl.sv
module shadow_cfg_ctrl
  import shadow_cfg_pkg::*;
#(
  parameter int IO_W = 16,
  parameter logic [IO_W-1:0] INDEX_PORT = 16'h0022,
  parameter logic [IO_W-1:0] DATA_PORT  = 16'h0024
) (
  input  logic            ioWrEn,
  input  logic [IO_W-1:0] ioAddr,
  output cfgStrobe_t      strobe
);
  always_comb begin
    strobe.loadIndex = ioWrEn && (ioAddr == INDEX_PORT);
    strobe.storeData = ioWrEn && (ioAddr == DATA_PORT);
  end
endmodule

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import shadow_cfg_pkg::*;
#(
  parameter int IO_W = 16,
  parameter int DATA_W = 8,
  parameter logic [IO_W-1:0] DATA_PORT = 16'h0024,
  parameter logic [DATA_W-1:0] REG_BASE = 8'h10,
  parameter int REG_COUNT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfgStrobe_t        strobe,
  input  logic [IO_W-1:0]   ioAddr,
  input  logic [DATA_W-1:0] ioWrData,
  output logic [DATA_W-1:0] ioRdData,
  output logic [DATA_W-1:0] policyReg,
  output logic [DATA_W-1:0] blockLoReg,
  output logic [DATA_W-1:0] blockHiReg
);
  localparam int OFS_POLICY = 1;
  localparam int OFS_BLKLO  = 2;
  localparam int OFS_BLKHI  = 3;
  localparam logic [DATA_W:0] WIN_END = {1'b0, REG_BASE} + (DATA_W+1)'(REG_COUNT);

  function automatic logic [DATA_W-1:0] resetValue(input int slot);
    case (slot)
      0:       return 8'h3F;
      1:       return 8'hF0;
      default: return '0;
    endcase
  endfunction

  logic [DATA_W-1:0] indexReg;
  logic [DATA_W-1:0] regFile [REG_COUNT];
  logic [DATA_W-1:0] slot;
  logic              indexHit;
  logic [REG_COUNT*DATA_W-1:0] regFlat;

  assign slot     = indexReg - REG_BASE;
  assign indexHit = ({1'b0, indexReg} >= {1'b0, REG_BASE}) && ({1'b0, indexReg} < WIN_END);

  always_ff @(posedge clk) begin
    if (!rst_n) indexReg <= '0;
    else if (strobe.loadIndex) indexReg <= ioWrData;
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) regFile[g] <= resetValue(g);
      else if (strobe.storeData && indexHit && (slot == DATA_W'(g))) regFile[g] <= ioWrData;
    end
    assign regFlat[g*DATA_W +: DATA_W] = regFile[g];
  end

  always_comb begin
    ioRdData = '1;
    if (ioAddr == DATA_PORT) begin
      ioRdData = '0;
      for (int i = 0; i < REG_COUNT; i++)
        if (indexHit && (slot == DATA_W'(i))) ioRdData = regFile[i];
    end
  end

  assign policyReg  = regFile[OFS_POLICY];
  assign blockLoReg = regFile[OFS_BLKLO];
  assign blockHiReg = regFile[OFS_BLKHI];

  // R3: a data write outside the window leaves every stored byte intact
  p_ignored_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.storeData && !indexHit |=> $stable(regFlat));
  // R2: any port other than the data port reads all ones
  p_other_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ioAddr != DATA_PORT |-> ioRdData == '1);
endmodule

// File: rtl/shadow_region_decode.sv
module shadow_region_decode
  import shadow_cfg_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] policyReg,
  input  logic [DATA_W-1:0] blockLoReg,
  input  logic [DATA_W-1:0] blockHiReg,
  output logic              inRange,
  output logic              rdInternal,
  output wrTarget_e         wrTarget
);
  localparam int SEG_W = 2;
  localparam int BLK_W = 2;
  localparam int BLKS  = 1 << BLK_W;
  localparam int SEG_LSB = ADDR_W - 2 - SEG_W;
  localparam int BLK_LSB = SEG_LSB - BLK_W;
  localparam logic [SEG_W-1:0] SEG_TOP = '1;

  logic [SEG_W-1:0] seg;
  logic [BLK_W-1:0] blk;
  logic [3:0]       segMaster;
  logic [BLKS-1:0]  segBlocks [4];
  logic [3:0]       shadowOn;

  assign inRange = &memAddr[ADDR_W-1 -: 2];
  assign seg     = memAddr[SEG_LSB +: SEG_W];
  assign blk     = memAddr[BLK_LSB +: BLK_W];

  // Segment 0 (C) uses the high nibble of blockHi, D the low nibble of blockLo, E its high nibble
  assign segMaster    = {1'b0, policyReg[6], policyReg[5], policyReg[4]};
  assign segBlocks[0] = blockHiReg[7:4];
  assign segBlocks[1] = blockLoReg[3:0];
  assign segBlocks[2] = blockLoReg[7:4];
  assign segBlocks[3] = '0;

  for (genvar g = 0; g < 4; g++) begin : g_seg
    assign shadowOn[g] = segMaster[g] & segBlocks[g][blk];
  end

  always_comb begin
    rdInternal = 1'b0;
    wrTarget   = WR_EXT;
    if (inRange) begin
      if (seg == SEG_TOP) begin
        if (policyReg[7]) wrTarget = WR_DRAM;
        else begin
          rdInternal = 1'b1;
          wrTarget   = WR_DROP;
        end
      end else if (shadowOn[seg]) begin
        rdInternal = 1'b1;
        wrTarget   = policyReg[3] ? WR_DRAM : WR_EXT;
      end
    end
  end

  p_below_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !inRange |-> !rdInternal && wrTarget == WR_EXT);
  p_top_modes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inRange && seg == SEG_TOP |-> (rdInternal ? wrTarget == WR_DROP : wrTarget == WR_DRAM));
  p_cde_no_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inRange && seg != SEG_TOP |-> wrTarget != WR_DROP);
  p_unshadowed_ext_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inRange && seg != SEG_TOP && !rdInternal |-> wrTarget == WR_EXT);
  p_master_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inRange && seg == 2'd0 && !policyReg[4] |-> !rdInternal);
endmodule

// File: rtl/shadow_region_ctl.sv
module shadow_region_ctl
  import shadow_cfg_pkg::*;
#(
  parameter int IO_W = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 20,
  parameter logic [IO_W-1:0] INDEX_PORT = 16'h0022,
  parameter logic [IO_W-1:0] DATA_PORT  = 16'h0024,
  parameter logic [DATA_W-1:0] REG_BASE = 8'h10,
  parameter int REG_COUNT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ioWrEn,
  input  logic [IO_W-1:0]   ioAddr,
  input  logic [DATA_W-1:0] ioWrData,
  output logic [DATA_W-1:0] ioRdData,
  input  logic [ADDR_W-1:0] memAddr,
  output logic              inRange,
  output logic              rdInternal,
  output logic [1:0]        wrTarget
);
  cfgStrobe_t        strobe;
  logic [DATA_W-1:0] policyReg, blockLoReg, blockHiReg;
  wrTarget_e         wrTargetEnum;

  shadow_cfg_ctrl #(.IO_W(IO_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)) ctrl_i (
    .ioWrEn(ioWrEn), .ioAddr(ioAddr), .strobe(strobe));

  shadow_cfg_regs #(.IO_W(IO_W), .DATA_W(DATA_W), .DATA_PORT(DATA_PORT),
                    .REG_BASE(REG_BASE), .REG_COUNT(REG_COUNT)) regs_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioRdData(ioRdData), .policyReg(policyReg), .blockLoReg(blockLoReg),
    .blockHiReg(blockHiReg));

  shadow_region_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) decode_i (
    .clk(clk), .rst_n(rst_n), .memAddr(memAddr), .policyReg(policyReg),
    .blockLoReg(blockLoReg), .blockHiReg(blockHiReg), .inRange(inRange),
    .rdInternal(rdInternal), .wrTarget(wrTargetEnum));

  assign wrTarget = wrTargetEnum;
endmodule

// File: tb/shadow_region_ctl_tb.sv
module shadow_region_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ioWrEn = 1'b0;
  logic [15:0] ioAddr = 16'h0000;
  logic [7:0]  ioWrData = 8'h00;
  logic [7:0]  ioRdData;
  logic [19:0] memAddr = 20'h00000;
  logic        inRange, rdInternal;
  logic [1:0]  wrTarget;

  int vectors = 0;
  int fails = 0;
  logic [7:0] mRegs [256];
  logic [7:0] mIndex;

  always #10 clk = ~clk;

  shadow_region_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .ioWrEn(ioWrEn), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioRdData(ioRdData), .memAddr(memAddr), .inRange(inRange),
    .rdInternal(rdInternal), .wrTarget(wrTarget));

  task automatic modelReset();
    for (int i = 0; i < 256; i++) mRegs[i] = 8'h00;
    mRegs[8'h10] = 8'h3F;
    mRegs[8'h11] = 8'hF0;
    mIndex = 8'h00;
  endtask

  task automatic predict(input logic [19:0] a, output logic hit, output logic rin,
                         output logic [1:0] wt);
    int seg, blk;
    logic on;
    hit = (a >= 20'hC0000);
    rin = 1'b0;
    wt  = 2'b00;
    seg = int'(a[17:16]);
    blk = int'(a[15:14]);
    on  = 1'b0;
    if (hit) begin
      if (seg == 3) begin
        if (mRegs[8'h11][7]) wt = 2'b01;
        else begin rin = 1'b1; wt = 2'b10; end
      end else begin
        if (seg == 0) on = mRegs[8'h11][4] && mRegs[8'h13][4+blk];
        if (seg == 1) on = mRegs[8'h11][5] && mRegs[8'h12][blk];
        if (seg == 2) on = mRegs[8'h11][6] && mRegs[8'h12][4+blk];
        if (on) begin
          rin = 1'b1;
          wt = mRegs[8'h11][3] ? 2'b01 : 2'b00;
        end
      end
    end
  endtask

  task automatic step(input string tag, input logic wr, input logic [15:0] a,
                      input logic [7:0] d, input logic [19:0] m);
    logic eHit, eRin;
    logic [1:0] eWt;
    logic [7:0] eRd;
    @(negedge clk);
    ioWrEn = wr; ioAddr = a; ioWrData = d; memAddr = m;
    #5;
    predict(m, eHit, eRin, eWt);
    if (a == 16'h0024) eRd = (mIndex >= 8'h10 && mIndex <= 8'h14) ? mRegs[mIndex] : 8'h00;
    else eRd = 8'hFF;
    vectors++;
    if (ioRdData !== eRd || inRange !== eHit || rdInternal !== eRin || wrTarget !== eWt) begin
      fails++;
      $display("FAIL %s addr=%05h io=%04h: rd=%02h hit=%b rin=%b wt=%b expected rd=%02h hit=%b rin=%b wt=%b",
               tag, m, a, ioRdData, inRange, rdInternal, wrTarget, eRd, eHit, eRin, eWt);
    end
    if (wr && a == 16'h0022) mIndex = d;
    if (wr && a == 16'h0024 && mIndex >= 8'h10 && mIndex <= 8'h14) mRegs[mIndex] = d;
  endtask

  task automatic setReg(input string tag, input logic [7:0] idx, input logic [7:0] val);
    step(tag, 1'b1, 16'h0022, idx, 20'hF1234);
    step(tag, 1'b1, 16'h0024, val, 20'hC4000);
  endtask

  task automatic readReg(input string tag, input logic [7:0] idx);
    step(tag, 1'b1, 16'h0022, idx, 20'h12345);
    step(tag, 1'b0, 16'h0024, 8'h00, 20'hBFFFF);
  endtask

  task automatic sweep(input string tag);
    for (int b = 0; b < 16; b++)
      step(tag, 1'b0, 16'h0024, 8'h00, 20'hC0000 + 20'(b * 20'h4000) + 20'((b * 20'h0123) & 20'h3FFF));
    step("R11", 1'b0, 16'h0024, 8'h00, 20'h00000);
    step("R11", 1'b0, 16'h0024, 8'h00, 20'hBFFFF);
    step("R11", 1'b0, 16'h0024, 8'h00, 20'h80000);
  endtask

  initial begin
    #(4_000_000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R4 and R1: reset values read back through the index port
    for (int i = 8'h10; i <= 8'h14; i++) readReg("R4", 8'(i));
    readReg("R1", 8'h00);
    // R2: non-data ports read all ones
    step("R2", 1'b0, 16'h0022, 8'h00, 20'hD0000);
    step("R2", 1'b0, 16'h0060, 8'h00, 20'hE0000);
    // R5, R10: decode at reset values
    sweep("R10");
    // R5: top segment switches to DRAM read, write dropped
    setReg("R5", 8'h11, 8'h00);
    sweep("R5");
    // R6/R7/R8: all block bits set, masters on, writes to bus
    setReg("R7", 8'h12, 8'hFF);
    setReg("R6", 8'h13, 8'hFF);
    setReg("R8", 8'h11, 8'h70);
    sweep("R8");
    // R9: write policy to DRAM
    setReg("R9", 8'h11, 8'h78);
    sweep("R9");
    // Asymmetric block patterns with one master at a time
    setReg("R7", 8'h12, 8'h5A);
    setReg("R6", 8'h13, 8'hC3);
    setReg("R6", 8'h11, 8'h10);
    sweep("R6");
    setReg("R7", 8'h11, 8'h28);
    sweep("R7");
    setReg("R8", 8'h11, 8'h48);
    sweep("R8");
    setReg("R9", 8'h11, 8'hF8);
    sweep("R9");
    // R3: writes outside the window are ignored
    setReg("R3", 8'h15, 8'h77);
    setReg("R3", 8'h0F, 8'h55);
    setReg("R3", 8'hFF, 8'hAA);
    readReg("R3", 8'h15);
    readReg("R3", 8'h0F);
    readReg("R3", 8'h11);
    sweep("R3");
    setReg("R4", 8'h10, 8'h81);
    setReg("R4", 8'h14, 8'h9C);
    readReg("R4", 8'h10);
    readReg("R4", 8'h14);
    // R12: the write cycle shows the old decode, the next shows the new one
    step("R12", 1'b1, 16'h0022, 8'h11, 20'hF8000);
    step("R12", 1'b1, 16'h0024, 8'h00, 20'hF8000);
    step("R12", 1'b0, 16'h0024, 8'h00, 20'hF8000);
    step("R12", 1'b1, 16'h0024, 8'h80, 20'hFFFFF);
    step("R12", 1'b0, 16'h0024, 8'h00, 20'hFFFFF);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule